// File: doc/BRIEF.md
# Byte-serial DMA command port

This block is the programmed-I/O front end of an eight-channel DMA controller. Software talks to it through two byte-wide ports. A write to the function port loads a command code and a channel number. Reads and writes on the execute port then move bytes in and out of the register chosen by that command. A hidden two-bit byte pointer walks multi-byte registers one byte per access, low byte first. Some commands act at once: setting a channel's mask, clearing it, and resetting the whole controller.

The per-channel registers live inside the block and drive the channel engines directly. These are the transfer mode, the I/O address, the memory address, the transfer count and the arbitration level. The engines report back through two pulse vectors. One marks that a channel moved data and the other marks that it reached its terminal count. The block gathers these into a two-byte status word that clears as it is read. A terminal count also disables the channel by setting its mask bit.

Top module: `dma_pio_port`

## Requirements
- R1: After reset, every mask bit is 1, status is 0 and `rdata_o` is 00. All mode, address and count registers are 0. Each channel's arbitration level equals its channel number. The command register holds a reserved code, so execute reads return 00 until the first function write.
- R2: A function-port byte takes the command code from bits 7:4 and the channel from bits 2:0; bit 3 is ignored. The write returns the byte pointer to 0.
- R3: Each execute access moves the byte pointer up by one, and pointer value k selects bits 8k+7:8k. Execute writes past the last byte of the selected register change nothing, and execute reads past it return 00.
- R4: Execute command codes work as follows. Code 0 reads and writes the 2-byte I/O address. Code 2 writes and code 3 reads the 3-byte memory address. Code 4 writes and code 5 reads the 2-byte transfer count. Code 7 reads and writes the 1-byte mode. Each register value appears on its output bus.
- R5: Codes 1, B, C, E and F and the immediate codes 9, A and D do nothing on the execute port: writes are dropped and reads return 00. Under the write-only codes 2 and 4, reads return 00. Under the read-only codes 3, 5 and 6, writes are dropped.
- R6: Code 8 reads and writes the 1-byte arbitration level of channels 0 and 4; their reset values are 0 and 4. For any other channel, code-8 writes are dropped, reads return 00, and the level output stays at the channel number.
- R7: A function write with code 9 sets the mask bit of the selected channel, and code A clears it. Both take effect at the clock edge that samples the function write.
- R8: A function write with code D sets all mask bits to 1 and clears all status bits. `ctl_rst_o` is high for exactly the following cycle. The mode, address, count and level registers keep their values.
- R9: In the status word, byte 0 holds activity for channels 0-3 in bits 3:0 and terminal count for channels 0-3 in bits 7:4. Byte 1 holds the same two fields for channels 4-7. `act_i`/`tc_i` pulses set the bits. Under code 6, reading a byte returns it and then clears it, but an event arriving in the cycle of that read is kept.
- R10: A `tc_i` pulse sets the channel's mask bit. This takes priority over a mask-clear command for the same channel in the same cycle.
- R11: `rdata_o` takes the read byte on the clock edge that samples an execute read. It holds that value until the next execute read.
- R12: A function write in the same cycle as an execute access wins. The execute access neither moves data nor advances the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fn_wr_i | input | 1 | Function-port byte write |
| exec_wr_i | input | 1 | Execute-port byte write |
| exec_rd_i | input | 1 | Execute-port byte read |
| wdata_i | input | 8 | Write data for either port |
| act_i | input | 8 | Per-channel pulse: channel moved data |
| tc_i | input | 8 | Per-channel pulse: terminal count reached |
| rdata_o | output | 8 | Registered execute-read data |
| mask_o | output | 8 | Per-channel disable bits |
| ctl_rst_o | output | 1 | One-cycle controller-reset pulse to the engines |
| mode_o | output | 64 | Mode byte per channel |
| ioaddr_o | output | 8*IO_AW | I/O address per channel |
| memaddr_o | output | 8*MEM_AW | Memory address per channel |
| count_o | output | 8*CNT_W | Transfer count per channel |
| arb_o | output | 32 | 4-bit arbitration level per channel |

## Verification
The hardest case to reach is a status event that lands in the same cycle as the read that clears its byte. Hitting it needs an exact-cycle overlap between an engine pulse and an execute read under code 6. The bench drives `act_i` in the very cycle of the execute read. It first expects the old byte back, then re-issues the status command and expects the new bit to have survived. Contested mask updates are reached the same way: a mask-clear function write is issued together with a terminal-count pulse. A function write is also overlapped with an execute write to show that the pointer does not move.

// File: rtl/dma_pio_pkg.sv
package dma_pio_pkg;
   localparam int NCH  = 8;
   localparam int CH_W = 3;

   localparam logic [3:0] FN_IO   = 4'h0;
   localparam logic [3:0] FN_MEMW = 4'h2;
   localparam logic [3:0] FN_MEMR = 4'h3;
   localparam logic [3:0] FN_CNTW = 4'h4;
   localparam logic [3:0] FN_CNTR = 4'h5;
   localparam logic [3:0] FN_STAT = 4'h6;
   localparam logic [3:0] FN_MODE = 4'h7;
   localparam logic [3:0] FN_ARB  = 4'h8;
   localparam logic [3:0] FN_MSET = 4'h9;
   localparam logic [3:0] FN_MCLR = 4'hA;
   localparam logic [3:0] FN_CRST = 4'hD;
   localparam logic [3:0] FN_IDLE = 4'hF;

   typedef enum logic [2:0] {
      RG_NONE, RG_IO, RG_MEM, RG_CNT, RG_MODE, RG_ARB, RG_STAT
   } rg_e;

   function automatic logic [7:0] pick_byte(input logic [31:0] v, input logic [1:0] p);
      return v[8*p +: 8];
   endfunction
endpackage

// File: rtl/dma_pio_decode.sv
module dma_pio_decode import dma_pio_pkg::*; #(
   parameter int         IO_NB    = 2,
   parameter int         MEM_NB   = 3,
   parameter int         CNT_NB   = 2,
   parameter logic [7:0] ARB_PROG = 8'h11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fn_wr_i,
   input  logic            exec_wr_i,
   input  logic            exec_rd_i,
   input  logic [7:0]      wdata_i,
   output rg_e             rg_o,
   output logic [CH_W-1:0] ch_o,
   output logic [1:0]      ptr_o,
   output logic            wr_o,
   output logic            rd_o,
   output logic            acc_rd_o,
   output logic            mset_o,
   output logic            mclr_o,
   output logic            crst_o
);
   logic [3:0]      fn_q;
   logic [CH_W-1:0] ch_q;
   logic [1:0]      ptr_q;
   logic            can_wr, can_rd;
   logic [2:0]      nb;
   logic            in_rng, live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fn_q  <= FN_IDLE;
         ch_q  <= '0;
         ptr_q <= '0;
      end else if (fn_wr_i) begin
         fn_q  <= wdata_i[7:4];
         ch_q  <= wdata_i[CH_W-1:0];
         ptr_q <= '0;
      end else if ((exec_wr_i || exec_rd_i) && ptr_q != 2'd3) begin
         ptr_q <= ptr_q + 2'd1;
      end
   end

   always_comb begin
      rg_o   = RG_NONE;
      can_wr = 1'b0;
      can_rd = 1'b0;
      nb     = 3'd0;
      case (fn_q)
         FN_IO:   begin rg_o = RG_IO;   can_wr = 1'b1; can_rd = 1'b1; nb = 3'(IO_NB);  end
         FN_MEMW: begin rg_o = RG_MEM;  can_wr = 1'b1;                nb = 3'(MEM_NB); end
         FN_MEMR: begin rg_o = RG_MEM;                 can_rd = 1'b1; nb = 3'(MEM_NB); end
         FN_CNTW: begin rg_o = RG_CNT;  can_wr = 1'b1;                nb = 3'(CNT_NB); end
         FN_CNTR: begin rg_o = RG_CNT;                 can_rd = 1'b1; nb = 3'(CNT_NB); end
         FN_STAT: begin rg_o = RG_STAT;                can_rd = 1'b1; nb = 3'd2;       end
         FN_MODE: begin rg_o = RG_MODE; can_wr = 1'b1; can_rd = 1'b1; nb = 3'd1;       end
         FN_ARB:  begin
            rg_o   = RG_ARB;
            can_wr = ARB_PROG[ch_q];
            can_rd = ARB_PROG[ch_q];
            nb     = 3'd1;
         end
         default: ;
      endcase
   end

   assign in_rng   = ({1'b0, ptr_q} < nb);
   assign live     = !fn_wr_i;
   assign wr_o     = live && exec_wr_i && can_wr && in_rng;
   assign rd_o     = live && exec_rd_i && can_rd && in_rng;
   assign acc_rd_o = live && exec_rd_i;
   assign mset_o   = fn_wr_i && (wdata_i[7:4] == FN_MSET);
   assign mclr_o   = fn_wr_i && (wdata_i[7:4] == FN_MCLR);
   assign crst_o   = fn_wr_i && (wdata_i[7:4] == FN_CRST);
   assign ch_o     = ch_q;
   assign ptr_o    = ptr_q;
endmodule

// File: rtl/dma_pio_chregs.sv
module dma_pio_chregs import dma_pio_pkg::*; #(
   parameter int         IO_AW    = 16,
   parameter int         MEM_AW   = 24,
   parameter int         CNT_W    = 16,
   parameter logic [7:0] ARB_PROG = 8'h11
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_i,
   input  rg_e                   rg_i,
   input  logic [CH_W-1:0]       ch_i,
   input  logic [1:0]            ptr_i,
   input  logic [7:0]            wdata_i,
   output logic [7:0]            rbyte_o,
   output logic [NCH*IO_AW-1:0]  io_o,
   output logic [NCH*MEM_AW-1:0] mem_o,
   output logic [NCH*CNT_W-1:0]  cnt_o,
   output logic [NCH*8-1:0]      mode_o,
   output logic [NCH*4-1:0]      arb_o
);
   localparam int IO_NB  = IO_AW / 8;
   localparam int MEM_NB = MEM_AW / 8;
   localparam int CNT_NB = CNT_W / 8;

   logic [7:0] rb [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [IO_AW-1:0]  io_q;
      logic [MEM_AW-1:0] mem_q;
      logic [CNT_W-1:0]  cnt_q;
      logic [7:0]        mode_q;
      logic [7:0]        arb_q;
      logic [7:0]        rb_c;
      logic              sel;

      assign sel = wr_i && (ch_i == CH_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            io_q   <= '0;
            mem_q  <= '0;
            cnt_q  <= '0;
            mode_q <= '0;
         end else if (sel) begin
            for (int b = 0; b < IO_NB; b++)
               if (rg_i == RG_IO && ptr_i == 2'(b)) io_q[8*b +: 8] <= wdata_i;
            for (int b = 0; b < MEM_NB; b++)
               if (rg_i == RG_MEM && ptr_i == 2'(b)) mem_q[8*b +: 8] <= wdata_i;
            for (int b = 0; b < CNT_NB; b++)
               if (rg_i == RG_CNT && ptr_i == 2'(b)) cnt_q[8*b +: 8] <= wdata_i;
            if (rg_i == RG_MODE) mode_q <= wdata_i;
         end
      end

      if (ARB_PROG[c]) begin : g_arb_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    arb_q <= 8'(c);
            else if (sel && rg_i == RG_ARB) arb_q <= wdata_i;
         end
      end else begin : g_arb_fix
         assign arb_q = 8'(c);
      end

      always_comb begin
         case (rg_i)
            RG_IO:   rb_c = pick_byte(32'(io_q), ptr_i);
            RG_MEM:  rb_c = pick_byte(32'(mem_q), ptr_i);
            RG_CNT:  rb_c = pick_byte(32'(cnt_q), ptr_i);
            RG_MODE: rb_c = mode_q;
            RG_ARB:  rb_c = arb_q;
            default: rb_c = 8'h00;
         endcase
      end

      assign rb[c] = rb_c;
      assign io_o[c*IO_AW +: IO_AW]    = io_q;
      assign mem_o[c*MEM_AW +: MEM_AW] = mem_q;
      assign cnt_o[c*CNT_W +: CNT_W]   = cnt_q;
      assign mode_o[c*8 +: 8]          = mode_q;
      assign arb_o[c*4 +: 4]           = arb_q[3:0];
   end

   assign rbyte_o = rb[ch_i];
endmodule

// File: rtl/dma_pio_state.sv
module dma_pio_state import dma_pio_pkg::*; (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mset_i,
   input  logic            mclr_i,
   input  logic            crst_i,
   input  logic [CH_W-1:0] imm_ch_i,
   input  logic [NCH-1:0]  act_i,
   input  logic [NCH-1:0]  tc_i,
   input  logic            stat_rd_i,
   input  logic [1:0]      ptr_i,
   output logic [NCH-1:0]  mask_o,
   output logic [15:0]     stat_o
);
   logic [NCH-1:0] mask_q, m_set, m_clr;
   logic [15:0]    stat_q, s_set, s_clr;

   always_comb begin
      s_set = '0;
      for (int c = 0; c < NCH; c++) begin
         s_set[(c/4)*8 + (c%4)]     = act_i[c];
         s_set[(c/4)*8 + 4 + (c%4)] = tc_i[c];
      end
      s_clr = !stat_rd_i ? 16'h0000 : (ptr_i == 2'd0 ? 16'h00FF : 16'hFF00);
      m_set = mset_i ? (NCH'(1) << imm_ch_i) : '0;
      m_clr = mclr_i ? (NCH'(1) << imm_ch_i) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         stat_q <= '0;
      end else if (crst_i) begin
         mask_q <= '1;
         stat_q <= '0;
      end else begin
         mask_q <= (mask_q & ~m_clr) | m_set | tc_i;
         stat_q <= (stat_q & ~s_clr) | s_set;
      end
   end

   assign mask_o = mask_q;
   assign stat_o = stat_q;
endmodule

// File: rtl/dma_pio_port.sv
module dma_pio_port import dma_pio_pkg::*; #(
   parameter int         IO_AW    = 16,
   parameter int         MEM_AW   = 24,
   parameter int         CNT_W    = 16,
   parameter logic [7:0] ARB_PROG = 8'h11
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fn_wr_i,
   input  logic                  exec_wr_i,
   input  logic                  exec_rd_i,
   input  logic [7:0]            wdata_i,
   input  logic [NCH-1:0]        act_i,
   input  logic [NCH-1:0]        tc_i,
   output logic [7:0]            rdata_o,
   output logic [NCH-1:0]        mask_o,
   output logic                  ctl_rst_o,
   output logic [NCH*8-1:0]      mode_o,
   output logic [NCH*IO_AW-1:0]  ioaddr_o,
   output logic [NCH*MEM_AW-1:0] memaddr_o,
   output logic [NCH*CNT_W-1:0]  count_o,
   output logic [NCH*4-1:0]      arb_o
);
   if (IO_AW % 8 != 0 || IO_AW < 8 || IO_AW > 24) begin : g_bad_io
      $error("IO_AW must be 8, 16 or 24");
   end
   if (MEM_AW % 8 != 0 || MEM_AW < 8 || MEM_AW > 24) begin : g_bad_mem
      $error("MEM_AW must be 8, 16 or 24");
   end
   if (CNT_W % 8 != 0 || CNT_W < 8 || CNT_W > 24) begin : g_bad_cnt
      $error("CNT_W must be 8, 16 or 24");
   end

   rg_e             rg;
   logic [CH_W-1:0] ch;
   logic [1:0]      ptr;
   logic            wr, rd, acc_rd, mset, mclr, crst;
   logic [7:0]      ch_byte, rd_byte, rdata_q;
   logic [15:0]     stat;
   logic            crst_q;

   dma_pio_decode #(
      .IO_NB(IO_AW/8), .MEM_NB(MEM_AW/8), .CNT_NB(CNT_W/8), .ARB_PROG(ARB_PROG)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .fn_wr_i(fn_wr_i), .exec_wr_i(exec_wr_i),
      .exec_rd_i(exec_rd_i), .wdata_i(wdata_i), .rg_o(rg), .ch_o(ch),
      .ptr_o(ptr), .wr_o(wr), .rd_o(rd), .acc_rd_o(acc_rd), .mset_o(mset),
      .mclr_o(mclr), .crst_o(crst)
   );

   dma_pio_chregs #(
      .IO_AW(IO_AW), .MEM_AW(MEM_AW), .CNT_W(CNT_W), .ARB_PROG(ARB_PROG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(wr), .rg_i(rg), .ch_i(ch), .ptr_i(ptr),
      .wdata_i(wdata_i), .rbyte_o(ch_byte), .io_o(ioaddr_o), .mem_o(memaddr_o),
      .cnt_o(count_o), .mode_o(mode_o), .arb_o(arb_o)
   );

   dma_pio_state u_state (
      .clk(clk), .rst_n(rst_n), .mset_i(mset), .mclr_i(mclr), .crst_i(crst),
      .imm_ch_i(wdata_i[CH_W-1:0]), .act_i(act_i), .tc_i(tc_i),
      .stat_rd_i(rd && rg == RG_STAT), .ptr_i(ptr), .mask_o(mask_o),
      .stat_o(stat)
   );

   assign rd_byte = (rg == RG_STAT) ? (ptr == 2'd0 ? stat[7:0] : stat[15:8]) : ch_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         crst_q  <= 1'b0;
      end else begin
         crst_q <= crst;
         if (acc_rd) rdata_q <= rd ? rd_byte : 8'h00;
      end
   end

   assign rdata_o   = rdata_q;
   assign ctl_rst_o = crst_q;
endmodule

// File: rtl/dma_pio_port_chk.sv
module dma_pio_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fn_wr_i,
   input logic       exec_rd_i,
   input logic [7:0] wdata_i,
   input logic [7:0] tc_i,
   input logic [7:0] rdata_o,
   input logic [7:0] mask_o,
   input logic       ctl_rst_o
);
   p_mset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_wr_i && wdata_i[7:4] == 4'h9) |=> mask_o[$past(wdata_i[2:0])]);

   p_mclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_wr_i && wdata_i[7:4] == 4'hA && !tc_i[wdata_i[2:0]]) |=> !mask_o[$past(wdata_i[2:0])]);

   p_crst_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_wr_i && wdata_i[7:4] == 4'hD) |=> (mask_o == 8'hFF && ctl_rst_o));

   p_crst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rst_o |-> $past(fn_wr_i && wdata_i[7:4] == 4'hD));

   p_tc_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_i != 8'h00) |=> ((mask_o & $past(tc_i)) == $past(tc_i)));

   p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(exec_rd_i && !fn_wr_i) |=> $stable(rdata_o));
endmodule

bind dma_pio_port dma_pio_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .fn_wr_i(fn_wr_i), .exec_rd_i(exec_rd_i),
   .wdata_i(wdata_i), .tc_i(tc_i), .rdata_o(rdata_o), .mask_o(mask_o),
   .ctl_rst_o(ctl_rst_o)
);

// File: tb/tb_dma_pio_port.sv
`timescale 1ns/100ps
module tb_dma_pio_port;
   localparam int IO_AW = 16, MEM_AW = 24, CNT_W = 16;
   localparam logic [1:0] OP_FN = 2'd0, OP_EW = 2'd1, OP_ER = 2'd2;
   localparam int NV = 59;
   // {op, data, expected read byte}
   localparam logic [17:0] VEC [NV] = '{
      {OP_FN,8'h02,8'h00}, {OP_EW,8'h34,8'h00}, {OP_EW,8'h12,8'h00}, {OP_EW,8'h99,8'h00},
      {OP_FN,8'h02,8'h00}, {OP_ER,8'h00,8'h34}, {OP_ER,8'h00,8'h12}, {OP_ER,8'h00,8'h00},
      {OP_FN,8'h25,8'h00}, {OP_EW,8'h56,8'h00}, {OP_EW,8'h34,8'h00}, {OP_EW,8'h12,8'h00},
      {OP_EW,8'hEE,8'h00},
      {OP_FN,8'h35,8'h00}, {OP_ER,8'h00,8'h56}, {OP_ER,8'h00,8'h34}, {OP_ER,8'h00,8'h12},
      {OP_ER,8'h00,8'h00},
      {OP_FN,8'h25,8'h00}, {OP_ER,8'h00,8'h00},
      {OP_FN,8'h43,8'h00}, {OP_EW,8'hAA,8'h00}, {OP_EW,8'hBB,8'h00},
      {OP_FN,8'h53,8'h00}, {OP_ER,8'h00,8'hAA}, {OP_ER,8'h00,8'hBB},
      {OP_FN,8'h53,8'h00}, {OP_EW,8'h77,8'h00},
      {OP_FN,8'h53,8'h00}, {OP_ER,8'h00,8'hAA},
      {OP_FN,8'h33,8'h00}, {OP_ER,8'h00,8'h00},
      {OP_FN,8'h7A,8'h00}, {OP_EW,8'h0D,8'h00}, {OP_EW,8'h44,8'h00},
      {OP_FN,8'h72,8'h00}, {OP_ER,8'h00,8'h0D}, {OP_ER,8'h00,8'h00},
      {OP_FN,8'h80,8'h00}, {OP_ER,8'h00,8'h00},
      {OP_FN,8'h84,8'h00}, {OP_ER,8'h00,8'h04},
      {OP_FN,8'h84,8'h00}, {OP_EW,8'h0C,8'h00},
      {OP_FN,8'h84,8'h00}, {OP_ER,8'h00,8'h0C},
      {OP_FN,8'h81,8'h00}, {OP_EW,8'h07,8'h00},
      {OP_FN,8'h81,8'h00}, {OP_ER,8'h00,8'h00},
      {OP_FN,8'h13,8'h00}, {OP_EW,8'h55,8'h00}, {OP_ER,8'h00,8'h00},
      {OP_FN,8'hF2,8'h00}, {OP_ER,8'h00,8'h00},
      {OP_FN,8'h92,8'h00}, {OP_ER,8'h00,8'h00},
      {OP_FN,8'h03,8'h00}, {OP_ER,8'h00,8'h00}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic fn_wr = 1'b0, exec_wr = 1'b0, exec_rd = 1'b0;
   logic [7:0] wdata = '0, act = '0, tc = '0;
   logic [7:0] rdata, mask;
   logic ctl_rst;
   logic [63:0] mode;
   logic [8*IO_AW-1:0] ioaddr;
   logic [8*MEM_AW-1:0] memaddr;
   logic [8*CNT_W-1:0] count;
   logic [31:0] arb;
   int nchk = 0, nerr = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dma_pio_port #(.IO_AW(IO_AW), .MEM_AW(MEM_AW), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .fn_wr_i(fn_wr), .exec_wr_i(exec_wr),
      .exec_rd_i(exec_rd), .wdata_i(wdata), .act_i(act), .tc_i(tc),
      .rdata_o(rdata), .mask_o(mask), .ctl_rst_o(ctl_rst), .mode_o(mode),
      .ioaddr_o(ioaddr), .memaddr_o(memaddr), .count_o(count), .arb_o(arb)
   );

   task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
      nchk++;
      if (a !== e) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the capturing rise
   task automatic op(input logic f, input logic w, input logic r, input logic [7:0] d);
      fn_wr = f; exec_wr = w; exec_rd = r; wdata = d;
      @(negedge clk);
      fn_wr = 1'b0; exec_wr = 1'b0; exec_rd = 1'b0; act = '0; tc = '0;
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mask", 32'(mask), 32'hFF);
      chk("R1 rdata", 32'(rdata), 32'h00);
      chk("R1 ctl_rst", 32'(ctl_rst), 32'h0);
      chk("R1 arb levels", arb, 32'h76543210);
      chk("R1 count ch3", 32'(count[3*CNT_W +: CNT_W]), 32'h0);
      op(1'b0, 1'b0, 1'b1, 8'h00);
      chk("R1 exec read before first command", 32'(rdata), 32'h00);

      // table walk: R2 R3 R4 R5 R6 R11
      for (int i = 0; i < NV; i++) begin
         logic [1:0] o;
         o = VEC[i][17:16];
         op(o == OP_FN, o == OP_EW, o == OP_ER, VEC[i][15:8]);
         if (o == OP_ER) chk($sformatf("R3/R4/R5/R6 vector %0d", i), 32'(rdata), 32'(VEC[i][7:0]));
      end
      chk("R4 ioaddr ch2", 32'(ioaddr[2*IO_AW +: IO_AW]), 32'h1234);
      chk("R4 memaddr ch5", 32'(memaddr[5*MEM_AW +: MEM_AW]), 32'h123456);
      chk("R4 count ch3", 32'(count[3*CNT_W +: CNT_W]), 32'hBBAA);
      chk("R2 mode ch2 via bit3 ignored", 32'(mode[2*8 +: 8]), 32'h0D);
      chk("R6 arb ch4 and fixed ch1", arb, 32'h765C3210);
      chk("R5 ioaddr ch3 untouched", 32'(ioaddr[3*IO_AW +: IO_AW]), 32'h0);

      // R11 hold across non-read cycles
      op(1'b1, 1'b0, 1'b0, 8'h72);
      op(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R11 rdata held", 32'(rdata), 32'h00);
      op(1'b0, 1'b0, 1'b1, 8'h00);
      chk("R11 rdata loads", 32'(rdata), 32'h0D);

      // R7 immediate mask commands
      op(1'b1, 1'b0, 1'b0, 8'hA5);
      chk("R7 clear mask ch5", 32'(mask), 32'hDF);
      op(1'b1, 1'b0, 1'b0, 8'hA2);
      chk("R7 clear mask ch2", 32'(mask), 32'hDB);
      op(1'b1, 1'b0, 1'b0, 8'h95);
      chk("R7 set mask ch5", 32'(mask), 32'hFB);

      // R10 terminal count sets mask, beats simultaneous clear
      tc = 8'h04;
      op(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R10 tc sets mask ch2", 32'(mask), 32'hFF);
      tc = 8'h40;
      op(1'b1, 1'b0, 1'b0, 8'hA6);
      chk("R10 tc wins over clear ch6", 32'(mask), 32'hFF);

      // R9 status layout and clear-on-read (tc ch2, tc ch6 already recorded)
      act = 8'h01;
      op(1'b0, 1'b0, 1'b0, 8'h00);
      tc = 8'h20;
      op(1'b0, 1'b0, 1'b0, 8'h00);
      op(1'b1, 1'b0, 1'b0, 8'h60);
      op(1'b0, 1'b0, 1'b1, 8'h00);
      chk("R9 status byte0", 32'(rdata), 32'h41);
      op(1'b0, 1'b0, 1'b1, 8'h00);
      chk("R9 status byte1", 32'(rdata), 32'h60);
      op(1'b1, 1'b0, 1'b0, 8'h60);
      act = 8'h02;
      op(1'b0, 1'b0, 1'b1, 8'h00);
      chk("R9 byte0 cleared by read", 32'(rdata), 32'h00);
      op(1'b0, 1'b0, 1'b1, 8'h00);
      chk("R9 byte1 cleared by read", 32'(rdata), 32'h00);
      op(1'b1, 1'b0, 1'b0, 8'h60);
      op(1'b0, 1'b0, 1'b1, 8'h00);
      chk("R9 event during clear survives", 32'(rdata), 32'h02);

      // R12 function write wins over execute access
      op(1'b1, 1'b0, 1'b0, 8'h06);
      op(1'b1, 1'b1, 1'b0, 8'h06);
      op(1'b0, 1'b1, 1'b0, 8'h11);
      op(1'b0, 1'b1, 1'b0, 8'h22);
      chk("R12 ioaddr ch6", 32'(ioaddr[6*IO_AW +: IO_AW]), 32'h2211);

      // R8 controller reset
      op(1'b1, 1'b0, 1'b0, 8'hA0);
      act = 8'h10;
      op(1'b1, 1'b0, 1'b0, 8'hA1);
      chk("R8 pre-reset mask", 32'(mask), 32'hFC);
      op(1'b1, 1'b0, 1'b0, 8'hD0);
      chk("R8 mask all set", 32'(mask), 32'hFF);
      chk("R8 ctl_rst pulse", 32'(ctl_rst), 32'h1);
      op(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R8 ctl_rst one cycle", 32'(ctl_rst), 32'h0);
      op(1'b1, 1'b0, 1'b0, 8'h60);
      op(1'b0, 1'b0, 1'b1, 8'h00);
      op(1'b0, 1'b0, 1'b1, 8'h00);
      chk("R8 status cleared", 32'(rdata), 32'h00);
      op(1'b1, 1'b0, 1'b0, 8'h02);
      op(1'b0, 1'b0, 1'b1, 8'h00);
      chk("R8 registers kept", 32'(rdata), 32'h34);

      done = 1;
      summary();
      $finish;
   end
endmodule